// File: doc/BRIEF.md
# I/O Cycle Contention Sequencer

This block models how a home-computer video controller stretches CPU I/O cycles by stopping the CPU clock. When an I/O request arrives, the block takes the 16-bit port address, a mode input and the level of the memory-request line. It selects a four-T-state pattern of steps. Each step either runs at once, or first waits for the contended-memory delay of the T-state in which the step begins and then runs. While the pattern plays out, the block drives a per-T-state clock-hold output. At the end it pulses a completion flag and reports the total cycle length, with pauses included.

One clock edge of the block is one T-state, and `frame_tstate` gives the position of the current T-state in the video frame. A request is taken only while the sequencer is idle. The clock-hold output covers the accepting edge's T-state and each later T-state of the pattern. The completion pulse and length appear one edge after the last T-state of the I/O cycle.

Top module: `io_contention_seq`

## Requirements
- R1: After a synchronous active-high reset, `clk_hold`, `busy` and `done` are 0 and `cycle_len` is 0. A reset in the middle of a pattern returns the block to idle with `clk_hold` low.
- R2: If the high byte is outside the contended window and the port is the controller's own (address bit 0 equal to 0), the pattern is one uncontended T-state followed by a contended step that runs for 3 T-states.
- R3: If the high byte is outside the window and the port is another (address bit 0 equal to 1), the cycle is 4 T-states with no pause, whatever the frame position.
- R4: If the high byte is inside the window and the port is the controller's own, the pattern is a contended step of 1 T-state followed by a contended step of 3 T-states.
- R5: If the high byte is inside the window and the port is another, the pattern is four contended steps of 1 T-state each. Each step takes the delay of the T-state in which it begins.
- R6: The delay for a T-state t is 0 outside the display area. The display area is t from 14335 up to 14335+192*224-1 with (t-14335) mod 224 below 128. Inside it, the delay is 6,5,4,3,2,1,0,0 for (t-14335) mod 8 equal to 0..7.
- R7: With `late_mode`=1 and `mreq_active`=0 at acceptance, no step pauses and the cycle is 4 T-states. With `late_mode`=1 and `mreq_active`=1, contention applies as in the older mode.
- R8: `clk_hold` is high for exactly the paused T-states, which number the cycle length minus 4. It is low whenever the block is idle.
- R9: `done` is high for one cycle, one edge after the last T-state. `cycle_len` then equals the total T-state count of the cycle.
- R10: An `io_req` raised while `busy` is high is ignored. It neither changes the running cycle nor starts another one.
- R11: The contended window is the address high byte from 0x40 to 0x7F inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O request, accepted when idle |
| port_addr | input | 16 | Port address of the request |
| mreq_active | input | 1 | Memory-request line level at acceptance |
| late_mode | input | 1 | 1 selects contention gated by memory request |
| frame_tstate | input | 17 | Current T-state position within the frame |
| clk_hold | output | 1 | CPU clock held during this T-state |
| busy | output | 1 | A pattern is in progress |
| done | output | 1 | One-cycle pulse at end of the I/O cycle |
| cycle_len | output | 6 | Total T-states of the finished cycle |

## Verification
A wrong step index, counter or latched pattern changes the number of held T-states, so the completion pulse comes early or late. The bench observes this at the ports within the same I/O cycle, as a mismatch in `cycle_len`, in the number of T-states before `done`, and in the count of `clk_hold` cycles. A fault in the delay lookup shows up only when a step begins at a frame position with a nonzero delay. For that reason, directed cases place step starts on line column 0, on columns 6, 7 and 127/128, and on the first and last T-states of the display area.

// File: rtl/iocs_pkg.sv
`timescale 1ns/1ps
package iocs_pkg;
  localparam int STEPS = 4;
  localparam int LEN_W = 3;
  localparam int DLY_W = 3;
  localparam int IDX_W = $clog2(STEPS);

  typedef enum logic [1:0] {ST_IDLE, ST_PAUSE, ST_RUN} st_e;

  // Contention flag and run length per step, plus index of the final step.
  typedef struct packed {
    logic [STEPS-1:0]            cont;
    logic [STEPS-1:0][LEN_W-1:0] len;
    logic [IDX_W-1:0]            last;
  } pat_t;

  typedef struct packed {
    st_e              st;
    logic [LEN_W-1:0] cnt;
    logic             hold;
  } entry_t;

  // Decide how a step opens: pause for the current delay or run straight away.
  function automatic entry_t step_entry(logic cont, logic [LEN_W-1:0] len,
                                        logic en, logic [DLY_W-1:0] dly);
    entry_t r;
    if (cont && en && (dly != '0)) begin
      r.st   = ST_PAUSE;
      r.cnt  = LEN_W'(dly - 1'b1);
      r.hold = 1'b1;
    end else begin
      r.st   = ST_RUN;
      r.cnt  = len - 1'b1;
      r.hold = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/iocs_pattern_decode.sv
`timescale 1ns/1ps
module iocs_pattern_decode
  import iocs_pkg::*;
#(
  parameter int             ADDR_W   = 16,
  parameter logic [7:0]     WIN_LO   = 8'h40,
  parameter logic [7:0]     WIN_HI   = 8'h7F,
  parameter logic [ADDR_W-1:0] OWN_MASK = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] OWN_VAL  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output pat_t              pat
);
  logic [7:0] hi_byte;
  logic       in_win;
  logic       own;

  assign hi_byte = addr[ADDR_W-1 -: 8];
  assign in_win  = (hi_byte >= WIN_LO) && (hi_byte <= WIN_HI);
  assign own     = ((addr & OWN_MASK) == OWN_VAL);

  always_comb begin
    pat.cont = '0;
    pat.last = '0;
    for (int i = 0; i < STEPS; i++) pat.len[i] = LEN_W'(1);
    case ({in_win, own})
      2'b00: begin                       // N:4
        pat.len[0] = LEN_W'(4);
      end
      2'b01: begin                       // N:1 C:3
        pat.cont   = 4'b0010;
        pat.len[1] = LEN_W'(3);
        pat.last   = IDX_W'(1);
      end
      2'b11: begin                       // C:1 C:3
        pat.cont   = 4'b0011;
        pat.len[1] = LEN_W'(3);
        pat.last   = IDX_W'(1);
      end
      default: begin                     // C:1 x4
        pat.cont = 4'b1111;
        pat.last = IDX_W'(STEPS-1);
      end
    endcase
  end
endmodule

// File: rtl/iocs_delay_lut.sv
`timescale 1ns/1ps
module iocs_delay_lut
  import iocs_pkg::*;
#(
  parameter int T_W         = 17,
  parameter int DISP_START  = 14335,
  parameter int LINE_T      = 224,
  parameter int DISP_LINES  = 192,
  parameter int DISP_ACTIVE = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [T_W-1:0]   tstate,
  output logic [DLY_W-1:0] dly
);
  localparam logic [T_W-1:0] START_V = T_W'(DISP_START);
  localparam logic [T_W-1:0] END_V   = T_W'(DISP_START + DISP_LINES*LINE_T);
  localparam logic [T_W-1:0] LINE_V  = T_W'(LINE_T);
  localparam logic [T_W-1:0] ACT_V   = T_W'(DISP_ACTIVE);

  logic [T_W-1:0] rel;
  logic [T_W-1:0] col;
  logic [2:0]     phase;
  logic           in_disp;

  always_comb begin
    rel     = tstate - START_V;
    col     = rel % LINE_V;
    phase   = col[2:0];
    in_disp = (tstate >= START_V) && (tstate < END_V) && (col < ACT_V);
    if (in_disp && (phase < 3'd6)) dly = DLY_W'(3'd6 - phase);
    else                           dly = '0;
  end

  a_r6_delay_cap: assert property (@(posedge clk) disable iff (rst)
    dly <= DLY_W'(6));
  a_r6_quiet_before_display: assert property (@(posedge clk) disable iff (rst)
    (tstate < START_V) |-> (dly == '0));
endmodule

// File: rtl/iocs_stepper.sv
`timescale 1ns/1ps
module iocs_stepper
  import iocs_pkg::*;
#(
  parameter int CL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  pat_t             pat_in,
  input  logic             en_in,
  input  logic [DLY_W-1:0] dly,
  output logic             clk_hold,
  output logic             busy,
  output logic             done,
  output logic [CL_W-1:0]  cycle_len
);
  st_e              st_q;
  logic [IDX_W-1:0] step_q;
  logic [IDX_W-1:0] step_nx;
  logic [LEN_W-1:0] cnt_q;
  logic [CL_W-1:0]  elapsed_q;
  logic [CL_W-1:0]  len_q;
  pat_t             pat_q;
  logic             en_q;
  logic             hold_q;
  logic             done_q;
  entry_t           first_e;
  entry_t           next_e;

  always_comb begin
    step_nx = step_q + 1'b1;
    first_e = step_entry(pat_in.cont[0], pat_in.len[0], en_in, dly);
    next_e  = step_entry(pat_q.cont[step_nx], pat_q.len[step_nx], en_q, dly);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      step_q    <= '0;
      cnt_q     <= '0;
      elapsed_q <= '0;
      len_q     <= '0;
      pat_q     <= '0;
      en_q      <= 1'b0;
      hold_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          hold_q <= 1'b0;
          if (req) begin
            pat_q     <= pat_in;
            en_q      <= en_in;
            step_q    <= '0;
            st_q      <= first_e.st;
            cnt_q     <= first_e.cnt;
            hold_q    <= first_e.hold;
            elapsed_q <= CL_W'(1);
          end
        end
        ST_PAUSE: begin
          elapsed_q <= elapsed_q + 1'b1;
          if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
            hold_q <= 1'b1;
          end else begin
            st_q   <= ST_RUN;
            cnt_q  <= pat_q.len[step_q] - 1'b1;
            hold_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (cnt_q != '0) begin
            cnt_q     <= cnt_q - 1'b1;
            elapsed_q <= elapsed_q + 1'b1;
            hold_q    <= 1'b0;
          end else if (step_q != pat_q.last) begin
            step_q    <= step_nx;
            st_q      <= next_e.st;
            cnt_q     <= next_e.cnt;
            hold_q    <= next_e.hold;
            elapsed_q <= elapsed_q + 1'b1;
          end else begin
            st_q   <= ST_IDLE;
            hold_q <= 1'b0;
            done_q <= 1'b1;
            len_q  <= elapsed_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clk_hold  = hold_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign cycle_len = len_q;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!clk_hold && !busy && !done));
  a_r8_hold_needs_busy: assert property (@(posedge clk) disable iff (rst)
    clk_hold |-> busy);
  a_r8_pause_cap: assert property (@(posedge clk) disable iff (rst)
    clk_hold |-> (cnt_q <= LEN_W'(5)));
  a_r7_late_no_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !en_q) |-> !clk_hold);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_len_floor: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycle_len >= CL_W'(STEPS)));
  a_r10_busy_holds_pattern: assert property (@(posedge clk) disable iff (rst)
    (busy && req) |=> (busy || done));
endmodule

// File: rtl/io_contention_seq.sv
`timescale 1ns/1ps
module io_contention_seq
  import iocs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int T_W         = 17,
  parameter int CL_W        = 6,
  parameter int DISP_START  = 14335,
  parameter int LINE_T      = 224,
  parameter int DISP_LINES  = 192,
  parameter int DISP_ACTIVE = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              mreq_active,
  input  logic              late_mode,
  input  logic [T_W-1:0]    frame_tstate,
  output logic              clk_hold,
  output logic              busy,
  output logic              done,
  output logic [CL_W-1:0]   cycle_len
);
  pat_t             pat;
  logic [DLY_W-1:0] dly;
  logic             cont_en;

  // Later mode only contends while a memory request is active.
  assign cont_en = !late_mode || mreq_active;

  iocs_pattern_decode #(
    .ADDR_W(ADDR_W)
  ) u_dec (
    .addr (port_addr),
    .pat  (pat)
  );

  iocs_delay_lut #(
    .T_W        (T_W),
    .DISP_START (DISP_START),
    .LINE_T     (LINE_T),
    .DISP_LINES (DISP_LINES),
    .DISP_ACTIVE(DISP_ACTIVE)
  ) u_lut (
    .clk    (clk),
    .rst    (rst),
    .tstate (frame_tstate),
    .dly    (dly)
  );

  iocs_stepper #(
    .CL_W(CL_W)
  ) u_step (
    .clk       (clk),
    .rst       (rst),
    .req       (io_req),
    .pat_in    (pat),
    .en_in     (cont_en),
    .dly       (dly),
    .clk_hold  (clk_hold),
    .busy      (busy),
    .done      (done),
    .cycle_len (cycle_len)
  );
endmodule

// File: tb/sim_io_contention_seq.sv
`timescale 1ns/1ps
module sim_io_contention_seq;
  localparam int FRAME = 69888;
  localparam int S     = 14335;
  localparam int LT    = 224;
  localparam int DEND  = S + 192*224;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0;
  logic [15:0] port_addr = '0;
  logic        mreq_active = 1'b0;
  logic        late_mode = 1'b0;
  logic [16:0] frame_tstate = '0;
  logic        clk_hold, busy, done;
  logic [5:0]  cycle_len;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  io_contention_seq u0 (
    .clk(clk), .rst(rst), .io_req(io_req), .port_addr(port_addr),
    .mreq_active(mreq_active), .late_mode(late_mode),
    .frame_tstate(frame_tstate), .clk_hold(clk_hold), .busy(busy),
    .done(done), .cycle_len(cycle_len)
  );

  initial forever #5 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one T-state; inputs and samples sit 1 ns after the edge.
  task automatic tick();
    @(posedge clk);
    #1;
    frame_tstate = (int'(frame_tstate) + 1 == FRAME) ? '0 : frame_tstate + 1'b1;
  endtask

  function automatic int dly_of(int t);
    int tt, col;
    tt = t % FRAME;
    if (tt < S || tt >= DEND) return 0;
    col = (tt - S) % LT;
    if (col >= 128) return 0;
    return ((col % 8) < 6) ? 6 - (col % 8) : 0;
  endfunction

  function automatic int exp_len(int f, logic [15:0] a, bit mq, bit lt);
    bit inwin, own, en;
    int c[4], x[4], n, t;
    inwin = (a[15:8] >= 8'h40) && (a[15:8] <= 8'h7F);
    own   = (a[0] == 1'b0);
    en    = !lt || mq;
    if (!inwin && !own)     begin n = 1; c[0] = 0; x[0] = 4; end
    else if (!inwin && own) begin n = 2; c[0] = 0; x[0] = 1; c[1] = 1; x[1] = 3; end
    else if (inwin && own)  begin n = 2; c[0] = 1; x[0] = 1; c[1] = 1; x[1] = 3; end
    else begin n = 4; for (int i = 0; i < 4; i++) begin c[i] = 1; x[i] = 1; end end
    t = f;
    for (int i = 0; i < n; i++) begin
      if (c[i] != 0 && en) t += dly_of(t);
      t += x[i];
    end
    return t - f;
  endfunction

  task automatic run_io(int f, logic [15:0] a, bit mq, bit lt, bit poke, string tag);
    int n, holds, exp;
    exp = exp_len(f, a, mq, lt);
    frame_tstate = 17'(f);
    port_addr = a; mreq_active = mq; late_mode = lt; io_req = 1'b1;
    tick();
    io_req = 1'b0;
    n = 0; holds = 0;
    while (!done && n < 100) begin
      n++;
      if (clk_hold) holds++;
      if (poke && n == 1) begin io_req = 1'b1; port_addr = a ^ 16'h8001; end
      else io_req = 1'b0;
      tick();
    end
    io_req = 1'b0;
    check(n == exp, tag, n, exp);
    check(int'(cycle_len) == exp, {tag, "/R9 len"}, int'(cycle_len), exp);
    check(holds == exp - 4, {tag, "/R8 holds"}, holds, exp - 4);
    check(clk_hold == 1'b0, "R8 hold at done", int'(clk_hold), 0);
    tick();
    check(done == 1'b0, "R9 single pulse", int'(done), 0);
    if (poke) begin
      tick();
      check(!busy && !done && !clk_hold, "R10 ignored request", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) tick();
    check(!clk_hold && !busy && !done && cycle_len == 0, "R1 reset", int'(busy), 0);
    rst = 1'b0;
    tick();

    run_io(S - 1, 16'h10FF, 0, 0, 0, "R3");
    run_io(S + 8, 16'h80FF, 0, 0, 1, "R3");
    run_io(S - 1, 16'h10FE, 0, 0, 0, "R2");
    run_io(S + 6, 16'h20FE, 0, 0, 0, "R2");
    run_io(S + 2, 16'h20FE, 0, 0, 1, "R2");
    run_io(S,     16'h40FE, 0, 0, 0, "R4");
    run_io(S + 5, 16'h7FFE, 0, 0, 0, "R4");
    run_io(S,     16'h40FF, 0, 0, 0, "R5");
    run_io(S + 3, 16'h5A01, 0, 0, 1, "R5");
    run_io(S - 2, 16'h60FF, 0, 0, 0, "R6 display start");
    run_io(S + 126, 16'h60FF, 0, 0, 0, "R6 line end");
    run_io(S + LT, 16'h60FF, 0, 0, 0, "R6 second line");
    run_io(DEND - LT + 125, 16'h60FF, 0, 0, 0, "R6 last line");
    run_io(DEND - 2, 16'h60FF, 0, 0, 0, "R6 display end");
    run_io(S, 16'h3FFF, 0, 0, 0, "R11 below");
    run_io(S, 16'h4001, 0, 0, 0, "R11 low edge");
    run_io(S, 16'h7F01, 0, 0, 0, "R11 high edge");
    run_io(S, 16'h80FF, 0, 0, 0, "R11 above");
    run_io(S, 16'h40FF, 0, 1, 0, "R7 late no mreq");
    run_io(S, 16'h40FE, 0, 1, 0, "R7 late no mreq own");
    run_io(S, 16'h40FF, 1, 1, 0, "R7 late mreq");

    for (int k = 0; k < 40; k++) begin
      int f;
      logic [15:0] a;
      f = S - 50 + int'($urandom % (DEND - S + 100));
      a = 16'($urandom);
      if (k % 2 == 0) a[15:8] = 8'h40 + 8'($urandom % 64);
      run_io(f, a, 1'($urandom), 1'($urandom), 1'($urandom), "R5 random");
      repeat (int'($urandom % 3)) tick();
    end

    frame_tstate = 17'(S);
    port_addr = 16'h40FF; late_mode = 0; io_req = 1'b1;
    tick();
    io_req = 1'b0;
    tick();
    rst = 1'b1;
    tick();
    check(!busy && !clk_hold && !done, "R1 mid reset", int'(busy), 0);
    rst = 1'b0;
    tick();
    run_io(S, 16'h40FF, 0, 0, 0, "R1 after reset");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule